// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of a read or write burst in a synchronous DRAM model or controller. A one-cycle start pulse loads a start column, a burst length code and an order bit; from the next cycle on, the block presents one column per clock together with a valid flag and a flag marking the final beat. Two wrap orders are supported. The sequential order counts upward inside an aligned block. The interleaved order flips the low address bits by the beat number. A full-page sequential mode runs until it is stopped.

A burst can be cut short on any cycle. A new start pulse abandons the running burst and begins the new one. A stop pulse ends it. Row and bank selection, data movement and command decoding belong to neighbouring blocks.

The controller is a three-state machine. IDLE waits for a start. BURST runs a bounded burst. PAGE runs an open-ended full-page burst. The transitions are:
- IDLE→BURST and IDLE→PAGE on a start. The target depends on the decoded length.
- BURST→IDLE on the final beat or on a stop.
- PAGE→IDLE on a stop.
- BURST or PAGE→BURST or PAGE on a start. This is a restart from the new column.

Top module: `sdr_burst_colgen`

## Requirements
- R1: After reset `valid_o`, `last_o` and `err_o` are low until a start is accepted.
- R2: A start pulse sampled on a rising edge makes `valid_o` high and `col_o` equal to the sampled start column in the following cycle (beat 0).
- R3: In sequential order with burst length N, beat k shows the start column with its low log2(N) bits replaced by (start + k) mod N; the upper bits stay fixed.
- R4: In interleaved order, beat k shows the start column XOR k, where k < N.
- R5: Length code encoding (3 bits): the values 0, 1, 2 and 3 select N = 1, 2, 4 and 8. Any code with bit 2 set selects full page.
- R6: `last_o` is high exactly on beat N-1 of a bounded burst, including beat 0 when N = 1. `valid_o` is low in the next cycle unless a new start arrives.
- R7: A full-page sequential burst advances the column by one modulo 512 each cycle, never raises `last_o`, and keeps running until stopped or restarted.
- R8: A start on any cycle, even one that also carries a stop, discards the running burst and begins the new burst in the next cycle.
- R9: A stop without a start makes `valid_o` and `last_o` low in the next cycle.
- R10: Interleaved order with a full-page code runs as an interleaved burst of length 8. `err_o` is high from its first beat and holds its value until the next accepted start, which reloads it. `err_o` is low for any legal combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a burst from `start_col_i` (restarts a running one) |
| stop_i | input | 1 | End the running burst |
| start_col_i | input | 9 | Start column, sampled with `start_i` |
| len_code_i | input | 3 | Burst length code, sampled with `start_i` |
| ileave_i | input | 1 | 1 = interleaved order, 0 = sequential, sampled with `start_i` |
| col_o | output | 9 | Column of the current beat |
| valid_o | output | 1 | A burst beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one of a bounded burst |
| err_o | output | 1 | The running or most recent burst used an illegal combination |

## Verification
The checks are scoreboard comparisons of every beat's column, valid, last and error flag. A corrupted beat counter or latched mask shows on `col_o` in the very next beat. It also moves `last_o` to the wrong cycle, so a bounded burst that is one beat too short or too long is caught when `valid_o` lingers or drops one cycle early. A wrong state shows within one cycle: `valid_o` stays high after a stop, or a full-page burst ends on its own. A badly latched error flag appears on the first beat and persists, so it is seen across the whole burst.

// File: rtl/sdr_col_pkg.sv
package sdr_col_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
    parameter int COL_W    = 9,
    parameter int CODE_W   = 3,
    parameter int MAX_LOG2 = 3
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              ileave_i,
    output logic [COL_W-1:0]  mask_o,
    output logic              full_o,
    output logic              illegal_o
);
    localparam int LO_W = CODE_W - 1;

    logic              page_req;
    logic [LO_W-1:0]   code_lo;
    logic [COL_W-1:0]  bound_mask;
    logic [COL_W-1:0]  clamp_mask;

    assign page_req = code_i[CODE_W-1];
    assign code_lo  = code_i[LO_W-1:0];

    // bit i of the wrap mask is set when the burst spans 2**(i+1) columns or more
    for (genvar gi = 0; gi < COL_W; gi++) begin : g_mask
        assign bound_mask[gi] = (gi < int'(code_lo));
        assign clamp_mask[gi] = (gi < MAX_LOG2);
    end

    always_comb begin
        full_o    = page_req && !ileave_i;
        illegal_o = page_req && ileave_i;
        if (full_o) begin
            mask_o = '1;
        end else if (illegal_o) begin
            mask_o = clamp_mask;
        end else begin
            mask_o = bound_mask;
        end
    end

endmodule

// File: rtl/bcg_col_calc.sv
module bcg_col_calc #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ileave_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;

    assign sum = base_i + beat_i;

    // per bit: bits outside the wrap mask keep the base; inside, pick the order
    for (genvar gi = 0; gi < COL_W; gi++) begin : g_bit
        always_comb begin
            if (!mask_i[gi]) begin
                col_o[gi] = base_i[gi];
            end else if (ileave_i) begin
                col_o[gi] = base_i[gi] ^ beat_i[gi];
            end else begin
                col_o[gi] = sum[gi];
            end
        end
    end

endmodule

// File: rtl/bcg_seq_fsm.sv
module bcg_seq_fsm
    import sdr_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    input  logic             ileave_i,
    input  logic             illegal_i,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] mask_o,
    output logic             ileave_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    seq_state_t       state_q, state_nx;
    logic [COL_W-1:0] base_q, beat_q, mask_q;
    logic             ileave_q, err_q;
    logic             final_beat;

    assign final_beat = (beat_q == mask_q);

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_nx = full_i ? ST_PAGE : ST_BURST;
            end
            ST_BURST: begin
                if (start_i)                     state_nx = full_i ? ST_PAGE : ST_BURST;
                else if (stop_i || final_beat)   state_nx = ST_IDLE;
            end
            ST_PAGE: begin
                if (start_i)     state_nx = full_i ? ST_PAGE : ST_BURST;
                else if (stop_i) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // burst context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            beat_q   <= '0;
            mask_q   <= '0;
            ileave_q <= 1'b0;
            err_q    <= 1'b0;
        end else if (start_i) begin
            base_q   <= start_col_i;
            beat_q   <= '0;
            mask_q   <= mask_i;
            ileave_q <= ileave_i;
            err_q    <= illegal_i;
        end else if (state_q != ST_IDLE) begin
            beat_q   <= beat_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        valid_o  = (state_q != ST_IDLE);
        last_o   = (state_q == ST_BURST) && final_beat;
        err_o    = err_q;
        base_o   = base_q;
        beat_o   = beat_q;
        mask_o   = mask_q;
        ileave_o = ileave_q;
    end

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (!valid_o && !last_o)) else $error("stop did not end burst"); // R9

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o) else $error("burst ran past last beat"); // R6

    AST_PAGE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE && !start_i && !stop_i) |=>
        (state_q == ST_PAGE && beat_q == $past(beat_q) + 1'b1 && !last_o)) else $error("full page broke"); // R7

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(err_o)) else $error("error flag changed without start"); // R10

endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
    import sdr_col_pkg::*;
#(
    parameter int COL_W    = 9,
    parameter int CODE_W   = 3,
    parameter int MAX_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] len_code_i,
    input  logic              ileave_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              last_o,
    output logic              err_o
);
    logic [COL_W-1:0] dec_mask, base, beat, mask_q;
    logic             dec_full, dec_illegal, ileave_q;

    bcg_len_decode #(.COL_W(COL_W), .CODE_W(CODE_W), .MAX_LOG2(MAX_LOG2)) i_dec (
        .code_i    (len_code_i),
        .ileave_i  (ileave_i),
        .mask_o    (dec_mask),
        .full_o    (dec_full),
        .illegal_o (dec_illegal)
    );

    bcg_seq_fsm #(.COL_W(COL_W)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .start_col_i (start_col_i),
        .mask_i      (dec_mask),
        .full_i      (dec_full),
        .ileave_i    (ileave_i),
        .illegal_i   (dec_illegal),
        .base_o      (base),
        .beat_o      (beat),
        .mask_o      (mask_q),
        .ileave_o    (ileave_q),
        .valid_o     (valid_o),
        .last_o      (last_o),
        .err_o       (err_o)
    );

    bcg_col_calc #(.COL_W(COL_W)) i_calc (
        .base_i   (base),
        .beat_i   (beat),
        .mask_i   (mask_q),
        .ileave_i (ileave_q),
        .col_o    (col_o)
    );

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i))) else $error("start not loaded"); // R2

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !start_i && !stop_i && !last_o) |=>
        (valid_o && ((col_o & ~mask_q) == ($past(col_o) & ~$past(mask_q))))) else $error("upper bits moved"); // R3

endmodule

// File: tb/test_sdr_burst_colgen.sv
module test_sdr_burst_colgen;

    localparam time CLK_HALF = 4ns;

    typedef struct {
        int         cyc;
        bit         v;
        logic [8:0] c;
        bit         l;
        bit         e;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0, ileave_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic [8:0] col_o;
    logic       valid_o, last_o, err_o;

    int   cyc_cnt = 0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #CLK_HALF clk = ~clk;
    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    sdr_burst_colgen i_sdr_burst_colgen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .start_col_i(start_col_i), .len_code_i(len_code_i), .ileave_i(ileave_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    // monitor: compare every expectation due in this cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc == cyc_cnt) begin
            exp_t x;
            x = sb.pop_front();
            total++;
            if (valid_o !== x.v || last_o !== x.l || err_o !== x.e ||
                (x.v && col_o !== x.c)) begin
                bad++;
                $display("FAIL %s cyc=%0d actual v=%0b col=%03h last=%0b err=%0b expected v=%0b col=%03h last=%0b err=%0b",
                         x.tag, cyc_cnt, valid_o, col_o, last_o, err_o, x.v, x.c, x.l, x.e);
            end
        end
    end

    function automatic logic [8:0] model_col(input logic [8:0] b, input int k, input int n, input bit il);
        logic [8:0] m, kk;
        m  = 9'(n - 1);
        kk = 9'(k);
        if (il) return b ^ kk;
        return (b & ~m) | ((b + kk) & m);
    endfunction

    // driver: one cycle of inputs plus the expectation for the following cycle
    task automatic step(input bit st, input bit sp, input logic [8:0] col, input logic [2:0] code,
                        input bit il, input bit ev, input logic [8:0] ec, input bit el,
                        input bit ee, input string tag);
        exp_t x;
        @(posedge clk); #1;
        start_i = st; stop_i = sp; start_col_i = col; len_code_i = code; ileave_i = il;
        x.cyc = cyc_cnt + 1; x.v = ev; x.c = ec; x.l = el; x.e = ee; x.tag = tag;
        sb.push_back(x);
    endtask

    task automatic run_burst(input logic [8:0] base, input logic [2:0] code, input bit il,
                             input bit stop_first, input int ncyc, input string tag);
        bit page, illegal;
        int n;
        page    = code[2] && !il;
        illegal = code[2] && il;
        n       = code[2] ? (il ? 8 : 512) : (1 << code[1:0]);
        for (int k = 0; k < ncyc; k++) begin
            if (k < n)
                step(k == 0, (k == 0) && stop_first, base, code, il,
                     1'b1, model_col(base, k, n, il), !page && (k == n - 1), illegal, tag);
            else
                step(1'b0, 1'b0, 9'h0, 3'd0, 1'b0, 1'b0, 9'h0, 1'b0, illegal, tag);
        end
    endtask

    task automatic stop_now(input bit ee, input string tag);
        step(1'b0, 1'b1, 9'h0, 3'd0, 1'b0, 1'b0, 9'h0, 1'b0, ee, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state, stop while idle has no effect
        step(0, 0, 9'h0, 3'd0, 0, 0, 9'h0, 0, 0, "R1 reset");
        step(0, 1, 9'h0, 3'd0, 0, 0, 9'h0, 0, 0, "R1 idle stop");
        // R2 R3 R5 R6 sequential length 4 from 0x0A6: A6 A7 A4 A5
        run_burst(9'h0A6, 3'd2, 0, 0, 6, "R3 seq4");
        // R3 sequential length 8 near the top: 1FD 1FE 1FF 1F8 ...
        run_burst(9'h1FD, 3'd3, 0, 0, 9, "R3 seq8");
        // R6 single beat
        run_burst(9'h055, 3'd0, 0, 0, 2, "R6 len1");
        // R4 interleaved length 2 and 8
        run_burst(9'h033, 3'd1, 1, 0, 3, "R4 il2");
        run_burst(9'h0C5, 3'd3, 1, 0, 9, "R4 il8");
        // R7 full page wraps 1FE 1FF 000 ... and R5 code 4; then R9 stop
        run_burst(9'h1FE, 3'd4, 0, 0, 6, "R7 page");
        stop_now(0, "R9 page stop");
        step(0, 0, 9'h0, 3'd0, 0, 0, 9'h0, 0, 0, "R9 stays idle");
        // R5 code 6 is also full page
        run_burst(9'h100, 3'd6, 0, 0, 4, "R5 code6 page");
        // R8 interrupt a length-8 burst after 3 beats with an interleaved length 4
        run_burst(9'h010, 3'd3, 0, 0, 3, "R8 first");
        run_burst(9'h107, 3'd2, 1, 0, 5, "R8 restart");
        // R8 start together with stop: start wins
        run_burst(9'h0F0, 3'd1, 0, 1, 3, "R8 start+stop");
        // R10 illegal combination runs as interleaved length 8, err set
        run_burst(9'h0AB, 3'd7, 1, 0, 10, "R10 illegal");
        run_burst(9'h000, 3'd0, 0, 0, 2, "R10 err cleared");
        // R9 stop a bounded burst mid-way
        run_burst(9'h020, 3'd3, 0, 0, 2, "R9 mid");
        stop_now(0, "R9 mid stop");
        step(0, 0, 9'h0, 3'd0, 0, 0, 9'h0, 0, 0, "R9 idle after");
        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_HALF * 2 * 20000);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule